// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes one memory request issued on behalf of a 32-lane warp and reduces it to the smallest set of aligned memory transactions. Each lane has an enable bit, a byte address and a log2 access size. Memory is treated as a sequence of fixed 32-byte segments. Because every legal lane access is aligned to its own size and is at most 16 bytes long, it always lies inside exactly one segment.

Once a request is accepted, the block runs a loop over the lanes that are still pending. Each step takes the pending lane with the lowest address and finds the 128-byte block that contains it. It then gathers every 32-byte segment in that block that any pending lane touches. The block emits the smallest 32-, 64- or 128-byte transaction that covers those segments and is aligned to its own length. All lanes inside the transaction are retired together, so duplicate addresses are handled as a broadcast.

Transactions leave on a valid/ready stream. The consumer may hold ready low for any number of cycles, and while it does, the descriptor must not change. The request side has its own handshake, and a new request is accepted only while no request is in progress. A one-cycle done pulse marks the end of each request.

Top module: `warp_coalescer`

## Requirements
- R1: `req_ready` is high exactly when no request is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a request is in progress, `req_ready` stays low and no new request is taken.
- R2: A lane's size code `s` means 2^s bytes. Only codes 0 to 4 are legal. An active lane is in error when its code is above 4 or its address is not a multiple of 2^s. Such a lane is flagged in `err_mask`, which is registered at acceptance and held until the next acceptance, and it appears in no transaction.
- R3: When all valid lanes fall in one 32-byte segment, the request yields exactly one transaction with size code 0. This includes the case where every lane uses the same address.
- R4: `txn_size` is 0 for 32 bytes, 1 for 64 bytes and 2 for 128 bytes. `txn_addr` is always a multiple of that length.
- R5: Each transaction is built around the pending lane with the lowest address and its 128-byte block. It is the smallest aligned transaction that covers every segment of that block touched by a pending lane. This holds even when the touched segments are sparse: segments 0 and 3 of one block give one 128-byte transaction.
- R6: A footprint that crosses a 32-byte boundary inside a 64-byte half yields one 64-byte transaction. A footprint that crosses a 128-byte boundary yields two transactions.
- R7: A footprint larger than 128 bytes is split into several transactions of at most 128 bytes each. For example, 32 lanes × 16 bytes contiguous yields four 128-byte transactions.
- R8: `txn_mask` bit i marks lane i as served. Every valid active lane is served by exactly one transaction, and each mask is non-empty.
- R9: While `txn_valid` is high and `txn_ready` is low, `txn_addr`, `txn_size`, `txn_mask` and `txn_store` stay constant and `txn_valid` stays high.
- R10: `done` is high for one cycle, in the cycle after the last transaction handshake. A request with no valid active lanes produces zero transactions and raises `done` one cycle after acceptance.
- R11: `txn_store` equals the `req_store` value that was captured when the request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; request can be taken |
| req_active | input | 32 | Per-lane enable |
| req_addr | input | 1024 | Lane i byte address in bits [32i+31:32i] |
| req_size | input | 96 | Lane i log2 size in bits [3i+2:3i] |
| req_store | input | 1 | 1 = store, 0 = load |
| txn_valid | output | 1 | Transaction descriptor valid |
| txn_ready | input | 1 | Consumer takes descriptor |
| txn_addr | output | 32 | Aligned transaction base address |
| txn_size | output | 2 | 0 = 32 B, 1 = 64 B, 2 = 128 B |
| txn_mask | output | 32 | Lanes served by this transaction |
| txn_store | output | 1 | Load/store flag of the request |
| done | output | 1 | One-cycle completion pulse |
| err_mask | output | 32 | Lanes rejected as misaligned or with an illegal size |

## Verification
The coalescing function is driven with address patterns from a small table. A contiguous aligned 128-byte span shows that a full-width transaction is chosen. An all-same-address request confirms the broadcast case. Byte-wide footprints that stay inside one segment, cross a segment boundary, or cross a 128-byte boundary separate the 32-byte, 64-byte and two-transaction outcomes. Strided and 512-byte footprints exercise splitting and the lowest-address-first order, and a sparse pair in segments 0 and 3 checks the smallest-cover rule. Directed cases cover misaligned and illegal-size lanes, an empty request, and a stalled consumer.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int SEG_LG = 5;   // 32-byte segment
  localparam int BLK_LG = 7;   // 128-byte block
  localparam int SEGS_PER_BLK = 1 << (BLK_LG - SEG_LG);
  localparam int MAX_SZC = 4;  // 16-byte lane access
  typedef enum logic [1:0] {TX32 = 2'd0, TX64 = 2'd1, TX128 = 2'd2} txsz_e;
endpackage

// File: rtl/coal_lane_check.sv
module coal_lane_check #(
  parameter int LANES = 32,
  parameter int AW    = 32
) (
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES*3-1:0]  szc,
  input  logic [LANES-1:0]    active,
  output logic [LANES-1:0]    ok_mask,
  output logic [LANES-1:0]    bad_mask
);
  import coal_pkg::*;
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [AW-1:0] a;
    logic [2:0]    s;
    logic          legal;
    assign a = addr[i*AW +: AW];
    assign s = szc[i*3 +: 3];
    always_comb begin
      legal = (int'(s) <= MAX_SZC) && ((a & ((AW'(1) << s) - AW'(1))) == '0);
    end
    assign ok_mask[i]  = active[i] & legal;
    assign bad_mask[i] = active[i] & ~legal;
  end
endmodule

// File: rtl/coal_min_pick.sv
module coal_min_pick #(
  parameter int LANES = 32,
  parameter int AW    = 32
) (
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES-1:0]    pending,
  output logic [AW-1:0]       min_addr
);
  always_comb begin
    logic found;
    found    = 1'b0;
    min_addr = '0;
    for (int i = 0; i < LANES; i++) begin
      if (pending[i] && (!found || addr[i*AW +: AW] < min_addr)) begin
        min_addr = addr[i*AW +: AW];
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/coal_seg_plan.sv
module coal_seg_plan #(
  parameter int LANES = 32,
  parameter int AW    = 32
) (
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES-1:0]    pending,
  input  logic [AW-1:0]       min_addr,
  output logic [AW-1:0]       tx_base,
  output logic [1:0]          tx_size,
  output logic [LANES-1:0]    tx_mask
);
  import coal_pkg::*;
  localparam int BW = AW - BLK_LG;

  logic [BW-1:0]           blk;
  logic [SEGS_PER_BLK-1:0] segs;
  logic [1:0]              pair;
  logic                    lo_any, hi_any;

  assign blk = min_addr[AW-1:BLK_LG];

  always_comb begin
    segs    = '0;
    tx_mask = '0;
    for (int i = 0; i < LANES; i++) begin
      if (pending[i] && addr[i*AW+BLK_LG +: BW] == blk) begin
        tx_mask[i] = 1'b1;
        segs[addr[i*AW+SEG_LG +: (BLK_LG-SEG_LG)]] = 1'b1;
      end
    end
  end

  assign lo_any = |segs[1:0];
  assign hi_any = |segs[3:2];
  assign pair   = hi_any ? segs[3:2] : segs[1:0];

  always_comb begin
    if (lo_any && hi_any) begin
      tx_size = TX128;
      tx_base = {blk, 7'b0};
    end else if (pair == 2'b11) begin
      tx_size = TX64;
      tx_base = {blk, hi_any, 6'b0};
    end else begin
      tx_size = TX32;
      tx_base = {blk, hi_any, pair[1], 5'b0};
    end
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES = 32,
  parameter int AW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES-1:0]    req_active,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES*3-1:0]  req_size,
  input  logic                req_store,
  output logic                txn_valid,
  input  logic                txn_ready,
  output logic [AW-1:0]       txn_addr,
  output logic [1:0]          txn_size,
  output logic [LANES-1:0]    txn_mask,
  output logic                txn_store,
  output logic                done,
  output logic [LANES-1:0]    err_mask
);
  logic [LANES*AW-1:0] addr_q;
  logic [LANES-1:0]    pend_q;
  logic                busy_q, store_q, done_q;
  logic [LANES-1:0]    err_q;
  logic [LANES-1:0]    ok_in, bad_in;
  logic [AW-1:0]       low_addr;
  logic                take, fire;
  logic [LANES-1:0]    pend_next;

  coal_lane_check #(.LANES(LANES), .AW(AW)) u_check (
    .addr(req_addr), .szc(req_size), .active(req_active),
    .ok_mask(ok_in), .bad_mask(bad_in)
  );

  coal_min_pick #(.LANES(LANES), .AW(AW)) u_pick (
    .addr(addr_q), .pending(pend_q), .min_addr(low_addr)
  );

  coal_seg_plan #(.LANES(LANES), .AW(AW)) u_plan (
    .addr(addr_q), .pending(pend_q), .min_addr(low_addr),
    .tx_base(txn_addr), .tx_size(txn_size), .tx_mask(txn_mask)
  );

  assign req_ready = !busy_q;
  assign take      = req_valid && req_ready;
  assign txn_valid = busy_q && (pend_q != '0);
  assign fire      = txn_valid && txn_ready;
  assign txn_store = store_q;
  assign done      = done_q;
  assign err_mask  = err_q;
  assign pend_next = pend_q & ~txn_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      pend_q  <= '0;
      busy_q  <= 1'b0;
      store_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        addr_q  <= req_addr;
        pend_q  <= ok_in;
        err_q   <= bad_in;
        store_q <= req_store;
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        if (pend_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else if (fire) begin
          pend_q <= pend_next;
          if (pend_next == '0) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  // R1: nothing is emitted while a new request can be taken
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !txn_valid);

  // R2: rejected lanes never appear in a transaction
  p_err_excluded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_mask & err_mask) == '0);

  // R4: legal size code and natural alignment of the base
  p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_size == 2'd0 && txn_addr[4:0] == 5'd0) ||
                   (txn_size == 2'd1 && txn_addr[5:0] == 6'd0) ||
                   (txn_size == 2'd2 && txn_addr[6:0] == 7'd0)));

  // R8: each transaction serves at least one lane still pending
  p_mask_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_mask != '0) && ((txn_mask & ~pend_q) == '0));

  // R9: descriptor held under back-pressure
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_addr) &&
      $stable(txn_size) && $stable(txn_mask) && $stable(txn_store));

  // R10: done is a single-cycle pulse with no transaction pending
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !txn_valid);
  p_done_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/warp_coalescer_tb_top.sv
module warp_coalescer_tb_top;
  localparam int L = 32;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic            req_valid = 1'b0, req_ready;
  logic [L-1:0]    req_active = '0;
  logic [L*AW-1:0] req_addr = '0;
  logic [L*3-1:0]  req_size = '0;
  logic            req_store = 1'b0;
  logic            txn_valid, txn_ready = 1'b1;
  logic [AW-1:0]   txn_addr;
  logic [1:0]      txn_size;
  logic [L-1:0]    txn_mask;
  logic            txn_store, done;
  logic [L-1:0]    err_mask;

  warp_coalescer #(.LANES(L), .AW(AW)) dut_i (.*);

  int checks = 0, failures = 0;
  bit finished = 0;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] stride;
    logic [2:0]  szc;
    logic [31:0] act;
    logic        st;
    logic [7:0]  cnt;
    logic [31:0] faddr;
    logic [1:0]  fsz;
    logic [31:0] fmask;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h1000, 32'd4,  3'd2, 32'hFFFFFFFF, 1'b0, 8'd1, 32'h1000, 2'd2, 32'hFFFFFFFF}, // R5 aligned 128B
    '{32'h2000, 32'd0,  3'd2, 32'hFFFFFFFF, 1'b1, 8'd1, 32'h2000, 2'd0, 32'hFFFFFFFF}, // R3 broadcast
    '{32'h3020, 32'd1,  3'd0, 32'hFFFFFFFF, 1'b0, 8'd1, 32'h3020, 2'd0, 32'hFFFFFFFF}, // R3 one segment
    '{32'h4010, 32'd1,  3'd0, 32'hFFFFFFFF, 1'b1, 8'd1, 32'h4000, 2'd1, 32'hFFFFFFFF}, // R6 64B
    '{32'h4070, 32'd1,  3'd0, 32'hFFFFFFFF, 1'b0, 8'd2, 32'h4060, 2'd0, 32'h0000FFFF}, // R6 two txns
    '{32'h5000, 32'd16, 3'd4, 32'hFFFFFFFF, 1'b1, 8'd4, 32'h5000, 2'd2, 32'h000000FF}, // R7 512B
    '{32'h6000, 32'd8,  3'd3, 32'h0000000F, 1'b0, 8'd1, 32'h6000, 2'd0, 32'h0000000F}, // R8 partial
    '{32'h7040, 32'd4,  3'd2, 32'h0000FFFF, 1'b1, 8'd1, 32'h7040, 2'd1, 32'h0000FFFF}, // R4 upper half
    '{32'h8000, 32'd32, 3'd2, 32'hFFFFFFFF, 1'b0, 8'd8, 32'h8000, 2'd2, 32'h0000000F}, // R7 strided
    '{32'h9000, 32'd96, 3'd2, 32'h00000003, 1'b1, 8'd1, 32'h9000, 2'd2, 32'h00000003}  // R5 sparse
  };

  int            n_txn;
  logic [31:0]   f_addr, union_m;
  logic [1:0]    f_size;
  logic [31:0]   f_mask;
  bit            overlap, misal, st_bad, got_done;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_pattern(input logic [31:0] base, input logic [31:0] stride,
                              input logic [2:0] szc, input logic [31:0] act, input logic st);
    for (int i = 0; i < L; i++) begin
      req_addr[i*AW +: AW] = base + 32'(i) * stride;
      req_size[i*3 +: 3]   = szc;
    end
    req_active = act;
    req_store  = st;
  endtask

  // Offers the loaded request, optional stall, then gathers all transactions.
  task automatic run_req(input int stall, input logic exp_st);
    logic [31:0] h_addr;
    logic [31:0] h_mask;
    @(negedge clk);
    req_valid = 1'b1;
    txn_ready = (stall == 0);
    @(negedge clk);
    req_valid = 1'b0;
    n_txn = 0; union_m = '0; overlap = 0; misal = 0; st_bad = 0; got_done = 0;
    f_addr = '0; f_size = '0; f_mask = '0;
    if (stall > 0) begin
      check(!req_ready, "R1 busy blocks", 64'(req_ready), 64'd0);
      h_addr = txn_addr; h_mask = txn_mask;
      for (int c = 0; c < stall; c++) begin
        @(negedge clk);
        check(txn_valid && txn_addr == h_addr && txn_mask == h_mask, "R9 hold",
              {txn_addr, txn_mask}, {h_addr, h_mask});
      end
      txn_ready = 1'b1;
    end
    for (int c = 0; c < 64; c++) begin
      if (done) begin got_done = 1; break; end
      if (txn_valid && txn_ready) begin
        if (n_txn == 0) begin f_addr = txn_addr; f_size = txn_size; f_mask = txn_mask; end
        if ((union_m & txn_mask) != 0) overlap = 1;
        union_m |= txn_mask;
        if (txn_size > 2 || (txn_addr & ((32'd32 << txn_size) - 1)) != 0) misal = 1;
        if (txn_store != exp_st) st_bad = 1;
        n_txn++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    check(req_ready && !txn_valid && !done && err_mask == 0, "R1 reset idle",
          {req_ready, txn_valid, done}, 64'h4);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      load_pattern(VECS[v].base, VECS[v].stride, VECS[v].szc, VECS[v].act, VECS[v].st);
      run_req(0, VECS[v].st);
      check(got_done, "R10 done seen", 64'(got_done), 64'd1);
      check(n_txn == int'(VECS[v].cnt), "R5/R6/R7 txn count", 64'(n_txn), 64'(VECS[v].cnt));
      check(f_addr == VECS[v].faddr && f_size == VECS[v].fsz, "R4/R5 first txn",
            {f_addr, 30'd0, f_size}, {VECS[v].faddr, 30'd0, VECS[v].fsz});
      check(f_mask == VECS[v].fmask, "R8 first mask", 64'(f_mask), 64'(VECS[v].fmask));
      check(union_m == VECS[v].act && !overlap, "R8 lanes served once",
            {31'd0, overlap, union_m}, 64'(VECS[v].act));
      check(!misal, "R4 alignment", 64'(misal), 64'd0);
      check(!st_bad, "R11 store flag", 64'(st_bad), 64'd0);
    end

    // R2: misaligned lane 5, illegal size on lane 0
    load_pattern(32'h100, 32'd4, 3'd2, 32'hFFFFFFFF, 1'b0);
    req_addr[5*AW +: AW] = 32'h102;
    req_size[0 +: 3] = 3'd5;
    run_req(0, 1'b0);
    check(err_mask == 32'h00000021, "R2 err_mask", 64'(err_mask), 64'h21);
    check(union_m == 32'hFFFFFFDE && n_txn == 1, "R2 lanes excluded",
          64'(union_m), 64'hFFFFFFDE);

    // R10: empty request
    load_pattern(32'h200, 32'd4, 3'd2, 32'h0, 1'b0);
    run_req(0, 1'b0);
    check(n_txn == 0 && got_done, "R10 empty request", 64'(n_txn), 64'd0);
    check(err_mask == 0, "R2 err_mask cleared", 64'(err_mask), 64'd0);

    // R9 / R1: back-pressure on a 512-byte footprint
    load_pattern(32'h5000, 32'd16, 3'd4, 32'hFFFFFFFF, 1'b1);
    run_req(4, 1'b1);
    check(n_txn == 4 && union_m == 32'hFFFFFFFF, "R7 split after stall",
          64'(n_txn), 64'd4);

    // R10: done is one cycle only
    @(negedge clk);
    check(!done && req_ready, "R10 done single cycle", 64'(done), 64'd0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule